// File: doc/BRIEF.md
# Glitchless redundant clock selector

This block picks one of two free-running clocks, a primary and a secondary, and passes it to a small set of identical clock outputs. A plain select input names the wanted source. When that input changes, the handover is made without runt pulses. The outgoing clock is first shut off on one of its own falling edges. The output then rests low until the incoming clock has seen that the outgoing side is idle. Only then is the incoming clock switched on, again on one of its own falling edges.

A forced-switch input covers the case where the abandoned clock has died, either stopped high or stopped low. It drops that clock's path at once, so the handover no longer waits on a clock that will never tick. An asynchronous output gate replaces every output with a chosen idle level, with no clock needed. A power-down input overrides everything and holds the outputs low. When power-down is released, the selected clock is brought back through the normal startup handover.

The block has no data path, so there is no valid/ready interface. Every pin is a plain control or clock level.

Top module: `clksel_redundant`

## Requirements
- R1: With sel = 0 the outputs carry the primary clock, and with sel = 1 the secondary clock. Once a handover is complete, output rising edges coincide with rising edges of the selected clock and repeat at its period.
- R2: After sel changes, the outputs pass at most three further rising edges of the previously selected clock. They then fall and stay low.
- R3: After the old clock's last falling edge on the outputs, at most three rising edges of the new clock go by before the outputs start following it. The two internal clock enables are never both on.
- R4: With the gate open, no force and no power-down, no output high or low phase produced across any switchover is shorter than the shorter input half-period.
- R5: If the old clock has stopped, a change of sel alone stalls the outputs at their current level. Raising force_sel (active high) removes the abandoned clock from the outputs immediately, and the outputs then follow the newly selected clock.
- R6: With out_en = 0 (gate closed) and pwr_dn = 0, every output equals idle_lvl immediately, without any clock edge. Clock edges have no effect on the outputs while the gate is closed.
- R7: All FANOUT outputs carry the same value at all times.
- R8: With pwr_dn = 1 (active high) all outputs are 0, regardless of out_en and idle_lvl. After pwr_dn falls, the selected clock reappears within three of its rising edges.
- R9: While rst_n = 0 (active low, asynchronous) the outputs are 0. After rst_n rises, the selected clock reaches the outputs no later than its third rising edge.
- R10: Consecutive changes of sel must be at least four periods of the slower clock apart. A reversal of sel made before the new clock reaches the outputs still ends glitch-free, with the outputs following the finally selected clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_pri | input | 1 | Primary clock source, chosen when sel = 0 |
| clk_sec | input | 1 | Secondary clock source, chosen when sel = 1 |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel | input | 1 | Source select: 0 primary, 1 secondary |
| force_sel | input | 1 | Forced switch, active high: drops the unselected source at once |
| out_en | input | 1 | Output gate, active high; when low the outputs show idle_lvl |
| idle_lvl | input | 1 | Level driven on the outputs while the gate is closed |
| pwr_dn | input | 1 | Power-down, active high: outputs forced to 0 |
| clk_out | output | FANOUT | Identical copies of the selected clock |

## Verification
The bench sweeps the moment of the select change across ten phase offsets in both directions. For each handover it counts the old-clock and new-clock edges that surround the quiet window on the output. A design that switched its enables on rising edges, or that let the new side start before the old side had stopped, would show up as a short output phase or as an edge that does not line up with the new clock. A selector that waited on a dead source would never resume after the forced switch. A selector whose gate or power-down needed a clock would leave the outputs toggling or at the wrong level. A reversal in the middle of a handover targets a handshake that could leave both enables on.

// File: rtl/clksel_pkg.sv
package clksel_pkg;

  // Two sources: index 0 is the primary clock, index 1 the secondary.
  localparam int NUM_LEGS = 2;

  // A leg is wanted when the select input names its index.
  function automatic logic leg_wanted(input logic sel, input int leg);
    return (int'(sel) == leg);
  endfunction

endpackage

// File: rtl/clksel_leg.sv
// One source path: synchronizes the request and the peer's busy flag into
// this clock, and opens the gate only on a falling edge of this clock.
module clksel_leg #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_in,
  input  logic kill,
  input  logic want_raw,
  input  logic peer_busy,
  output logic en,
  output logic busy,
  output logic gated
);

  localparam int TOP = SYNC_STAGES - 1;

  logic [TOP:0] want_sync;
  logic [TOP:0] peer_sync;
  logic         want_s;
  logic         peer_s;

  always_ff @(posedge clk_in or posedge kill) begin
    if (kill) begin
      want_sync <= '0;
      peer_sync <= '1;
    end else begin
      want_sync <= {want_sync[TOP-1:0], want_raw};
      peer_sync <= {peer_sync[TOP-1:0], peer_busy};
    end
  end

  assign want_s = want_sync[TOP];
  assign peer_s = peer_sync[TOP];

  // Enable moves only while this clock is low, so no high phase is cut.
  always_ff @(negedge clk_in or posedge kill) begin
    if (kill) en <= 1'b0;
    else      en <= want_s & ~peer_s;
  end

  // Busy while wanting or passing: the peer must wait on both.
  assign busy  = want_s | en;
  assign gated = clk_in & en;

  // R2: a leg that is no longer wanted has closed its path.
  p_off_when_unwanted_r2: assert property (@(posedge clk_in) disable iff (kill)
    !want_s |-> !en)
    else $error("leg enabled while not wanted");

  // R3: a closed leg stays closed while its peer is busy.
  p_wait_for_peer_r3: assert property (@(negedge clk_in) disable iff (kill)
    (!en && peer_s) |=> !en)
    else $error("leg opened while peer busy");

endmodule

// File: rtl/clksel_outgate.sv
// Asynchronous output stage: power-down, then idle gate, then clock; fans out.
module clksel_outgate #(
  parameter int FANOUT = 2
) (
  input  logic              mux_clk,
  input  logic              out_en,
  input  logic              idle_lvl,
  input  logic              pwr_dn,
  output logic [FANOUT-1:0] clk_out
);

  logic drive;

  always_comb begin
    if (pwr_dn)       drive = 1'b0;
    else if (!out_en) drive = idle_lvl;
    else              drive = mux_clk;
  end

  for (genvar f = 0; f < FANOUT; f++) begin : g_fan
    assign clk_out[f] = drive;
  end

endmodule

// File: rtl/clksel_redundant.sv
module clksel_redundant
  import clksel_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FANOUT      = 2
) (
  input  logic              clk_pri,
  input  logic              clk_sec,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              force_sel,
  input  logic              out_en,
  input  logic              idle_lvl,
  input  logic              pwr_dn,
  output logic [FANOUT-1:0] clk_out
);

  logic [NUM_LEGS-1:0] clk_leg;
  logic [NUM_LEGS-1:0] want_raw;
  logic [NUM_LEGS-1:0] kill;
  logic [NUM_LEGS-1:0] en;
  logic [NUM_LEGS-1:0] busy;
  logic [NUM_LEGS-1:0] gated;
  logic                mux_clk;

  assign clk_leg = {clk_sec, clk_pri};

  for (genvar i = 0; i < NUM_LEGS; i++) begin : g_leg
    assign want_raw[i] = leg_wanted(sel, i);
    // Reset, power-down, or a forced drop of the unselected source.
    assign kill[i] = ~rst_n | pwr_dn | (force_sel & ~want_raw[i]);

    clksel_leg #(
      .SYNC_STAGES(SYNC_STAGES)
    ) u_leg (
      .clk_in   (clk_leg[i]),
      .kill     (kill[i]),
      .want_raw (want_raw[i]),
      .peer_busy(busy[NUM_LEGS-1-i]),
      .en       (en[i]),
      .busy     (busy[i]),
      .gated    (gated[i])
    );
  end

  assign mux_clk = |gated;

  clksel_outgate #(
    .FANOUT(FANOUT)
  ) u_gate (
    .mux_clk (mux_clk),
    .out_en  (out_en),
    .idle_lvl(idle_lvl),
    .pwr_dn  (pwr_dn),
    .clk_out (clk_out)
  );

  // R3: never two open paths at once.
  always_comb begin
    p_one_leg_r3: assert (!(en[0] === 1'b1 && en[1] === 1'b1))
      else $error("both source paths open");
  end

  // R7: every fan-out copy agrees.
  p_fanout_match_r7: assert property (@(posedge clk_sec) disable iff (!rst_n)
    ($countones(clk_out) == 0) || ($countones(clk_out) == FANOUT))
    else $error("fan-out copies differ");

  // R8: power-down holds every output low.
  p_pd_low_r8: assert property (@(posedge clk_pri) disable iff (!rst_n)
    pwr_dn |-> (clk_out == '0))
    else $error("output active in power-down");

endmodule

// File: tb/clksel_redundant_tb.sv
`timescale 1ns/1ps
module clksel_redundant_tb;
  localparam int  FANOUT   = 2;
  localparam real PRI_HALF = 5.0;
  localparam real SEC_HALF = 7.0;
  localparam real MIN_W    = 5.0;

  logic clk = 0, clk_pri = 0, clk_sec = 0;
  logic rst_n = 0, sel = 0, force_sel = 0, out_en = 1, idle_lvl = 0, pwr_dn = 0;
  logic [FANOUT-1:0] clk_out;

  bit pri_run = 1, log_on = 0, mon_on = 0, done = 0;
  int n_chk = 0, n_fail = 0, n_glitch = 0, n_mism = 0;
  realtime out_r[$], out_f[$], pri_r[$], sec_r[$];
  realtime last_rise = 0, last_fall = 0;

  clksel_redundant #(.SYNC_STAGES(2), .FANOUT(FANOUT)) u_dut (
    .clk_pri(clk_pri), .clk_sec(clk_sec), .rst_n(rst_n), .sel(sel),
    .force_sel(force_sel), .out_en(out_en), .idle_lvl(idle_lvl),
    .pwr_dn(pwr_dn), .clk_out(clk_out));

  // 250 MHz bench clock, offset so it never shares an instant with the sources.
  initial begin #0.25; forever #2 clk = ~clk; end
  initial forever begin #PRI_HALF; if (pri_run) clk_pri = ~clk_pri; end
  initial begin #0.5; forever begin #SEC_HALF; clk_sec = ~clk_sec; end end

  always @(posedge clk_out[0]) begin
    if (log_on) out_r.push_back($realtime);
    if (mon_on && ($realtime - last_fall) < MIN_W - 0.01) n_glitch++;
    last_rise = $realtime;
  end
  always @(negedge clk_out[0]) begin
    if (log_on) out_f.push_back($realtime);
    if (mon_on && ($realtime - last_rise) < MIN_W - 0.01) n_glitch++;
    last_fall = $realtime;
  end
  always @(posedge clk_pri) if (log_on) pri_r.push_back($realtime);
  always @(posedge clk_sec) if (log_on) sec_r.push_back($realtime);
  always @(negedge clk) if (clk_out[0] !== clk_out[1]) n_mism++;

  task automatic chk(input string req, input bit ok, input string what,
                     input real act, input real exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0.3f expected %0.3f", req, what, act, exp);
    end
  endtask

  task automatic clear_logs();
    out_r.delete(); out_f.delete(); pri_r.delete(); sec_r.delete();
  endtask

  function automatic int count_in(input realtime q[$], input realtime lo, input realtime hi);
    int n = 0;
    foreach (q[i]) if (q[i] > lo && q[i] < hi) n++;
    return n;
  endfunction

  function automatic real last_period();
    int s = out_r.size();
    if (s < 2) return 0.0;
    return out_r[s-1] - out_r[s-2];
  endfunction

  // One handover, checked against R1, R2, R3.
  task automatic run_switch(input bit to_sec, input int off);
    realtime t0, g, gap, tfall;
    int k, n_old, n_new, n_hit;
    real newper, per;
    @(posedge clk);
    #(off + 0.3);
    clear_logs();
    log_on = 1;
    t0 = $realtime;
    sel = to_sec;
    #260;
    log_on = 0;
    newper = to_sec ? 2.0 * SEC_HALF : 2.0 * PRI_HALF;
    k = -1; gap = 0;
    for (int i = 0; i + 1 < out_r.size(); i++) begin
      g = out_r[i+1] - out_r[i];
      if (g > gap) begin gap = g; k = i; end
    end
    if (k < 0 || k + 2 >= out_r.size()) begin
      chk("R1", 0, "handover edges present", out_r.size(), 3);
      return;
    end
    tfall = out_r[k];
    for (int i = out_f.size() - 1; i >= 0; i--) if (out_f[i] > out_r[k]) tfall = out_f[i];
    if (to_sec) begin
      n_old = count_in(pri_r, t0, out_r[k] + 0.01);
      n_new = count_in(sec_r, tfall, out_r[k+1] - 0.01);
      n_hit = count_in(sec_r, out_r[k+1] - 0.01, out_r[k+1] + 0.01);
    end else begin
      n_old = count_in(sec_r, t0, out_r[k] + 0.01);
      n_new = count_in(pri_r, tfall, out_r[k+1] - 0.01);
      n_hit = count_in(pri_r, out_r[k+1] - 0.01, out_r[k+1] + 0.01);
    end
    per = out_r[k+2] - out_r[k+1];
    chk("R2", (n_old >= 1) && (n_old <= 3), "old-clock edges passed", n_old, 3);
    chk("R3", n_new <= 3, "new-clock edges while low", n_new, 3);
    chk("R1", n_hit == 1, "first edge aligned to new clock", n_hit, 1);
    chk("R1", (per > newper - 0.01) && (per < newper + 0.01), "period after handover", per, newper);
  endtask

  initial begin
    int n;
    real per;
    // R9: reset holds the outputs low.
    #50;
    chk("R9", clk_out == '0, "output in reset", clk_out, 0);
    @(posedge clk);
    clear_logs();
    log_on = 1;
    rst_n = 1;
    #100;
    log_on = 0;
    n = (out_r.size() > 0) ? count_in(pri_r, 0.0, out_r[0] + 0.01) : 99;
    chk("R9", (n >= 1) && (n <= 3), "primary edges to first output edge", n, 3);
    per = (out_r.size() > 1) ? out_r[1] - out_r[0] : 0.0;
    chk("R1", (per > 9.99) && (per < 10.01), "primary period after reset", per, 10.0);
    mon_on = 1;

    // R1/R2/R3/R4: sweep the select-change phase in both directions.
    for (int off = 0; off < 10; off++) begin
      run_switch(1'b1, off);
      run_switch(1'b0, off);
    end

    // R10: reversal in the middle of a handover.
    @(posedge clk); #0.3;
    sel = 1;
    #60;
    sel = 0;
    clear_logs(); log_on = 1;
    #300;
    log_on = 0;
    per = last_period();
    chk("R10", (per > 9.99) && (per < 10.01), "period after reversal", per, 10.0);
    chk("R4", n_glitch == 0, "short phases so far", n_glitch, 0);

    // R6: asynchronous gate to the idle level.
    mon_on = 0;
    @(posedge clk); #0.3;
    out_en = 0; idle_lvl = 1;
    #0.1;
    chk("R6", clk_out == '1, "idle high", clk_out, 3);
    clear_logs(); log_on = 1;
    #50;
    log_on = 0;
    chk("R6", (out_r.size() == 0) && (clk_out == '1), "no edges while gated", out_r.size(), 0);
    idle_lvl = 0;
    #0.1;
    chk("R6", clk_out == '0, "idle low", clk_out, 0);
    out_en = 1;

    // R8: power-down overrides the gate, then restarts cleanly.
    #30;
    out_en = 0; idle_lvl = 1; pwr_dn = 1;
    #0.1;
    chk("R8", clk_out == '0, "power-down over idle high", clk_out, 0);
    out_en = 1;
    clear_logs(); log_on = 1;
    #60;
    log_on = 0;
    chk("R8", (out_r.size() == 0) && (clk_out == '0), "no edges in power-down", out_r.size(), 0);
    idle_lvl = 0;
    @(posedge clk); #0.3;
    clear_logs(); log_on = 1;
    pwr_dn = 0;
    #150;
    log_on = 0;
    n = (out_r.size() > 0) ? count_in(pri_r, 0.0, out_r[0] + 0.01) : 99;
    chk("R8", n <= 3, "primary edges to restart", n, 3);
    per = last_period();
    chk("R8", (per > 9.99) && (per < 10.01), "period after power-down", per, 10.0);

    // R5: primary stops high; switch stalls without force, completes with it.
    @(posedge clk_pri); #1;
    pri_run = 0;
    #20;
    chk("R5", clk_out == '1, "output follows stopped primary", clk_out, 3);
    clear_logs(); log_on = 1;
    sel = 1;
    #200;
    log_on = 0;
    chk("R5", (out_r.size() == 0) && (clk_out == '1), "stalled without force", out_r.size(), 0);
    force_sel = 1;
    #0.1;
    chk("R5", clk_out == '0, "dead source dropped at once", clk_out, 0);
    clear_logs(); log_on = 1;
    #150;
    log_on = 0;
    per = last_period();
    chk("R5", (per > 13.99) && (per < 14.01), "secondary after forced switch", per, 14.0);
    pri_run = 1;
    #50;
    force_sel = 0;
    #100;
    mon_on = 1;
    run_switch(1'b0, 3);

    chk("R4", n_glitch == 0, "short phases overall", n_glitch, 0);
    chk("R7", n_mism == 0, "fan-out mismatches", n_mism, 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule